// File: doc/BRIEF.md
# Two-Wire Register Slave with Address Autoincrement

This block is a slave on a two-wire serial bus (clock plus open-drain data) that gives a bus master read and write access to a byte-wide register file with an 8-bit register address. Its 7-bit bus address is the fixed pattern `100110x`. The low bit `x` comes from a strap input, so two copies can share one bus. Both bus lines are oversampled by the system clock through two-flop synchronisers. Start, stop and SCL edges are detected on the synchronised samples.

A write transfer carries the register address as its first byte after the bus address. Every later byte is written to the next register in turn. A read transfer returns bytes starting at the register pointer, which is the register address most recently set by a write transfer. The pointer advances after each byte that is transferred. The register file sits outside the block. It sees a register address and write data together with one-cycle write and read strobes, and it answers a read strobe with combinational read data. The block only pulls SDA low and never drives it high. Clock stretching and 10-bit addressing are not supported.

Top module: `twi_reg_slave`

## Requirements
- R1: A falling SDA while SCL is high (a start) in any state, including in the middle of a byte or as a repeated start, restarts bus-address reception with cleared bit counters.
- R2: A rising SDA while SCL is high (a stop) returns the slave to idle. A byte cut short by a stop produces no strobe.
- R3: The slave answers bus address `{1,0,0,1,1,0,addr_sel_i}`, received in the upper 7 bits of the first byte. On a match it pulls SDA low for the whole ninth SCL pulse, for either strap value.
- R4: On an address mismatch SDA is never pulled, and no read or write strobe occurs until the next start.
- R5: Every byte is shifted most significant bit first, both into and out of the slave.
- R6: In a write transfer (direction bit 0) the second byte sets the register pointer. Each later byte gives one single-cycle `reg_we_o` with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte. The pointer then increments and wraps from 0xFF to 0x00.
- R7: In a read transfer (direction bit 1) each byte is fetched with one single-cycle `reg_re_o` at the current pointer. `reg_rdata_i` is driven out on SDA, and the pointer increments after each fetch.
- R8: A not-acknowledge from the master after a read byte ends the transfer. SDA is released and no further read strobe occurs.
- R9: During and just after reset, SDA is released and both strobes are low.
- R10: The SDA pull-low enable changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 1 | Strap giving the least significant bus-address bit |
| sda_pull_o | output | 1 | When high, the pad pulls SDA low |
| reg_addr_o | output | 8 | Register pointer presented to the register file |
| reg_wdata_o | output | 8 | Byte to be written |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_re_o | output | 1 | Single-cycle read strobe |
| reg_rdata_i | input | 8 | Combinational read data for `reg_addr_o` |

## Verification
The bench builds the block with its default parameters: two synchroniser stages and the bus-address prefix `100110`. With these defaults the full 8-bit pointer range is reachable, so a two-byte burst starting at 0xFF shows the wrap to 0x00. The short synchroniser delay also lets a bus phase of ten system clocks resolve every edge long before the next bus phase. The strap is driven both ways, so a bus address that matches one strap value can be shown to be ignored under the other.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DEVADR = 3'd1,
    ST_DEVACK = 3'd2,
    ST_REGADR = 3'd3,
    ST_WRDATA = 3'd4,
    ST_SLVACK = 3'd5,
    ST_RDDATA = 3'd6,
    ST_MSTACK = 3'd7
  } twi_state_t;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[CHAIN_W-WIDTH-1:0], d};
    end else begin : g_single
      always_comb chain_d = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/twi_bus_cond.sv
module twi_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_prev_q;
  logic sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/twi_engine.sv
module twi_engine
  import twi_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b100110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic              addr_sel,
  input  logic [BYTE_W-1:0] rdata,
  output logic              pull,
  output logic              we,
  output logic              re,
  output logic [BYTE_W-1:0] ptr,
  output logic [BYTE_W-1:0] wdata
);
  twi_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic              rw_q, rw_d;
  logic              pull_q, pull_d;
  logic              we_q, we_d;
  logic              re_q, re_d;
  logic              mack_q, mack_d;
  logic              byte_full;
  logic              addr_hit;

  assign byte_full = (cnt_q == CNT_W'(BYTE_W));
  assign addr_hit  = (rx_q[BYTE_W-1:1] == {DEV_ADDR_HI, addr_sel});

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    pull_d  = pull_q;
    mack_d  = mack_q;
    we_d    = 1'b0;
    re_d    = 1'b0;

    // strobe follow-up: advance pointer, load fetched byte
    if (we_q) ptr_d = ptr_q + 1'b1;
    if (re_q) begin
      ptr_d  = ptr_q + 1'b1;
      tx_d   = rdata;
      pull_d = ~rdata[BYTE_W-1];
    end

    if (start_det) begin
      state_d = ST_DEVADR;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else begin
      case (state_q)
        ST_DEVADR, ST_REGADR, ST_WRDATA: begin
          if (scl_rise) begin
            rx_d  = {rx_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && byte_full) begin
            cnt_d = '0;
            if (state_q == ST_DEVADR) begin
              if (addr_hit) begin
                rw_d    = rx_q[0];
                pull_d  = 1'b1;
                state_d = ST_DEVACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_REGADR) begin
              ptr_d   = rx_q;
              pull_d  = 1'b1;
              state_d = ST_SLVACK;
            end else begin
              we_d    = 1'b1;
              pull_d  = 1'b1;
              state_d = ST_SLVACK;
            end
          end
        end
        ST_DEVACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            cnt_d  = '0;
            if (rw_q) begin
              re_d    = 1'b1;
              state_d = ST_RDDATA;
            end else begin
              state_d = ST_REGADR;
            end
          end
        end
        ST_SLVACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            cnt_d   = '0;
            state_d = ST_WRDATA;
          end
        end
        ST_RDDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (byte_full) begin
              pull_d  = 1'b0;
              state_d = ST_MSTACK;
            end else begin
              tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
              pull_d = ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_MSTACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (mack_q) begin
              re_d    = 1'b1;
              state_d = ST_RDDATA;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      pull_q  <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      pull_q  <= pull_d;
      we_q    <= we_d;
      re_q    <= re_d;
      mack_q  <= mack_d;
    end
  end

  assign pull  = pull_q;
  assign we    = we_q;
  assign re    = re_q;
  assign ptr   = ptr_q;
  assign wdata = rx_q;
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_ADDR_HI = 6'b100110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic rst_sync_n;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  twi_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  twi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({scl_i, sda_i}),
    .q     ({scl_s, sda_s})
  );

  twi_bus_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_engine #(.DEV_ADDR_HI(DEV_ADDR_HI)) u_engine (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .addr_sel  (addr_sel_i),
    .rdata     (reg_rdata_i),
    .pull      (sda_pull_o),
    .we        (reg_we_o),
    .re        (reg_re_o),
    .ptr       (reg_addr_o),
    .wdata     (reg_wdata_o)
  );
endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       scl_s,
  input logic       sda_pull_o,
  input logic       reg_we_o,
  input logic       reg_re_o,
  input logic [7:0] reg_addr_o
);
  // R6 / R7: strobes never overlap
  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({reg_we_o, reg_re_o}));

  // R6: write strobe lasts one cycle
  a_r6_we_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_we_o |=> !reg_we_o);

  // R6: pointer advances by one after a write
  a_r6_we_advances: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_we_o |=> (reg_addr_o == $past(reg_addr_o) + 8'd1));

  // R7: read strobe lasts one cycle
  a_r7_re_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_re_o |=> !reg_re_o);

  // R7: pointer advances by one after a fetch
  a_r7_re_advances: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_re_o |=> (reg_addr_o == $past(reg_addr_o) + 8'd1));

  // R10: pull-low enable holds while SCL stays high
  a_r10_pull_steady_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull_o));
endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .scl_s      (scl_s),
  .sda_pull_o (sda_pull_o),
  .reg_we_o   (reg_we_o),
  .reg_re_o   (reg_re_o),
  .reg_addr_o (reg_addr_o)
);

// File: tb/twi_reg_slave_tb.sv
module twi_reg_slave_tb;
  localparam int PH = 10;
  localparam logic [5:0] HI = 6'b100110;
  localparam int NVEC = 6;
  // each entry: {register address, data byte}
  localparam logic [15:0] VEC [NVEC] = '{16'h003C, 16'h01A5, 16'h7F81,
                                         16'h8000, 16'hC3FF, 16'hFE5A};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, scl_m, sda_m, strap;
  logic       pull, we, re;
  logic [7:0] addr, wdata, rdata;
  wire        sda_line = sda_m & ~pull;

  logic [7:0] mem [256];
  logic [7:0] expm [256];
  int we_cnt, re_cnt, pull_cyc, r10_viol;
  int checks, errors;
  logic pull_prev;

  assign rdata = mem[addr];

  twi_reg_slave u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .addr_sel_i  (strap),
    .sda_pull_o  (pull),
    .reg_addr_o  (addr),
    .reg_wdata_o (wdata),
    .reg_we_o    (we),
    .reg_re_o    (re),
    .reg_rdata_i (rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      we_cnt <= 0; re_cnt <= 0; pull_cyc <= 0; r10_viol <= 0;
      pull_prev <= 1'b0;
    end else begin
      if (we) begin mem[addr] <= wdata; we_cnt <= we_cnt + 1; end
      if (re) re_cnt <= re_cnt + 1;
      if (pull) pull_cyc <= pull_cyc + 1;
      if (scl_m && (pull != pull_prev)) r10_viol <= r10_viol + 1;
      pull_prev <= pull;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; idle(PH); scl_m = 1'b1; idle(PH);
    sda_m = 1'b0; idle(PH); scl_m = 1'b0; idle(PH);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; idle(PH); scl_m = 1'b1; idle(PH); sda_m = 1'b1; idle(PH);
  endtask

  task automatic clk_bit(input logic b, output logic rb);
    sda_m = b; idle(PH);
    scl_m = 1'b1; idle(PH / 2);
    rb = sda_line; idle(PH / 2);
    scl_m = 1'b0; idle(PH);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic rb;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], rb);
    clk_bit(1'b1, rb);
    ack = ~rb;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic rb;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, rb);
      d[i] = rb;
    end
    clk_bit(~mack, rb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int w0, r0, p0;
    checks = 0; errors = 0;
    for (int i = 0; i < 256; i++) expm[i] = 8'h00;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 1'b0;
    idle(5);
    chk("R9 pull in reset", pull, 0);
    chk("R9 strobes in reset", {we, re}, 0);
    rst_n = 1'b1;
    idle(5);
    chk("R9 pull after reset", pull, 0);
    chk("R9 strobes after reset", {we, re}, 0);

    // table: single write then pointer-set + read back (R3 R5 R6 R7 R8)
    for (int v = 0; v < NVEC; v++) begin
      bus_start();
      send_byte({HI, 1'b0, 1'b0}, ack); chk("R3 ack write addr", ack, 1);
      send_byte(VEC[v][15:8], ack);     chk("R6 ack reg addr", ack, 1);
      send_byte(VEC[v][7:0], ack);      chk("R6 ack data", ack, 1);
      bus_stop();
      expm[VEC[v][15:8]] = VEC[v][7:0];
      chk("R6 written byte", mem[VEC[v][15:8]], expm[VEC[v][15:8]]);
      bus_start();
      send_byte({HI, 1'b0, 1'b0}, ack);
      send_byte(VEC[v][15:8], ack);
      bus_start();
      send_byte({HI, 1'b0, 1'b1}, ack); chk("R3 ack read addr", ack, 1);
      recv_byte(1'b0, d);
      chk("R5 R7 read back msb first", d, expm[VEC[v][15:8]]);
      chk("R8 released after nack", pull, 0);
      bus_stop();
    end

    // strap = 1: matching and non-matching low address bit (R3 R4)
    strap = 1'b1;
    bus_start();
    send_byte({HI, 1'b1, 1'b0}, ack); chk("R3 strap1 ack", ack, 1);
    send_byte(8'h20, ack);
    send_byte(8'hC7, ack);
    bus_stop();
    expm[8'h20] = 8'hC7;
    chk("R3 strap1 write", mem[8'h20], 8'hC7);
    w0 = we_cnt; r0 = re_cnt; p0 = pull_cyc;
    bus_start();
    send_byte({HI, 1'b0, 1'b0}, ack); chk("R4 mismatch no ack", ack, 0);
    send_byte(8'h20, ack);
    send_byte(8'h11, ack);
    bus_stop();
    chk("R4 no write strobe", we_cnt - w0, 0);
    chk("R4 no read strobe", re_cnt - r0, 0);
    chk("R4 sda never pulled", pull_cyc - p0, 0);
    chk("R4 register untouched", mem[8'h20], expm[8'h20]);
    strap = 1'b0;

    // burst write with autoincrement (R6)
    w0 = we_cnt;
    bus_start();
    send_byte({HI, 1'b0, 1'b0}, ack);
    send_byte(8'h40, ack);
    send_byte(8'h12, ack); send_byte(8'h34, ack); send_byte(8'h56, ack);
    bus_stop();
    expm[8'h40] = 8'h12; expm[8'h41] = 8'h34; expm[8'h42] = 8'h56;
    chk("R6 burst strobes", we_cnt - w0, 3);
    chk("R6 burst byte 0", mem[8'h40], 8'h12);
    chk("R6 burst byte 1", mem[8'h41], 8'h34);
    chk("R6 burst byte 2", mem[8'h42], 8'h56);

    // burst read with master acks then nack (R7 R8)
    bus_start();
    send_byte({HI, 1'b0, 1'b0}, ack);
    send_byte(8'h40, ack);
    r0 = re_cnt;
    bus_start();
    send_byte({HI, 1'b0, 1'b1}, ack);
    recv_byte(1'b1, d); chk("R7 burst read 0", d, 8'h12);
    recv_byte(1'b1, d); chk("R7 burst read 1", d, 8'h34);
    recv_byte(1'b0, d); chk("R7 burst read 2", d, 8'h56);
    idle(PH);
    chk("R8 sda released", pull, 0);
    chk("R8 no fetch after nack", re_cnt - r0, 3);
    bus_stop();

    // pointer wrap 0xFF -> 0x00 (R6)
    bus_start();
    send_byte({HI, 1'b0, 1'b0}, ack);
    send_byte(8'hFF, ack);
    send_byte(8'hE1, ack); send_byte(8'h9B, ack);
    bus_stop();
    chk("R6 wrap last reg", mem[8'hFF], 8'hE1);
    chk("R6 wrap reg zero", mem[8'h00], 8'h9B);

    // stop in the middle of a byte (R2)
    w0 = we_cnt;
    bus_start();
    send_byte({HI, 1'b0, 1'b0}, ack);
    begin
      logic rb;
      clk_bit(1'b0, rb); clk_bit(1'b1, rb); clk_bit(1'b0, rb);
    end
    bus_stop();
    idle(4 * PH);
    chk("R2 no strobe after cut byte", we_cnt - w0, 0);
    chk("R2 sda released after stop", pull, 0);
    bus_start();
    send_byte({HI, 1'b0, 1'b0}, ack); chk("R2 ack after stop", ack, 1);
    send_byte(8'h60, ack); send_byte(8'h3D, ack);
    bus_stop();
    chk("R2 write after stop", mem[8'h60], 8'h3D);

    // repeated start in the middle of a data byte (R1)
    w0 = we_cnt;
    bus_start();
    send_byte({HI, 1'b0, 1'b0}, ack);
    send_byte(8'h50, ack);
    begin
      logic rb;
      clk_bit(1'b1, rb); clk_bit(1'b0, rb); clk_bit(1'b1, rb); clk_bit(1'b1, rb);
    end
    bus_start();
    send_byte({HI, 1'b0, 1'b0}, ack); chk("R1 ack after restart", ack, 1);
    send_byte(8'h51, ack);
    send_byte(8'h22, ack);
    bus_stop();
    chk("R1 partial byte dropped", mem[8'h50], 8'h00);
    chk("R1 write after restart", mem[8'h51], 8'h22);
    chk("R1 single strobe", we_cnt - w0, 1);

    chk("R10 pull steady while scl high", r10_viol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule